// File: doc/BRIEF.md
# PCI Configuration Cycle Decoder

This block sits on the target side of a PCI or PCI-X bus interface. It watches each address phase and decides whether an inbound configuration transaction belongs to this device. To claim the access it needs the device-select line (`idsel`), a configuration command on the command/byte-enable lines, a Type 0 address and an accepted function number. When it claims, it latches a DWORD register index and the direction. It raises `devsel` one clock later. In the data phase it writes or reads a small register array, one byte lane at a time.

A mode input selects between two index schemes. In conventional or ordinary PCI-X operation, the index is the 6-bit register field and the space is 64 DWORDs. In PCI-X Mode 2, the 4-bit upper register field is joined above it to form a 10-bit index into a 1024-DWORD space. Only the first `NUM_REGS` DWORDs exist. DWORD 64 (byte offset 100h) reads as an all-zero extended capability header, which marks an empty extended list. All higher offsets read zero and ignore writes.

The multi-function flag is bit 7 of the header-type byte, which is bit 23 of DWORD 3. It lives in the register array and is written by ordinary configuration writes. It sets whether function 1 is answered. Both accepted functions share the same register array. Completion handling, parity and real register contents are outside this block.

Top module: `cfg_cycle_decoder`

## Requirements
- R1: An address phase (`addrValid`=1 while idle) is claimed only if `idsel`=1, the command is a configuration access, `adBus[1:0]`=00 and the function is accepted. After a claim, `devsel` is 1 in the cycle after the address phase.
- R2: A configuration command with `adBus[1:0]` not equal to 00 (for example Type 1) is not claimed and changes no register.
- R3: Only command code 1010b (configuration read) and 1011b (configuration write) on `cbeN` during the address phase count as configuration accesses. Any other code is not claimed.
- R4: The function number is `adBus[10:8]`. With the multi-function flag (DWORD 3 bit 23, reset 0) clear, only function 0 is claimed. With the flag set, functions 0 and 1 are claimed. Other numbers are never claimed.
- R5: When `mode2`=0, the index is `adBus[7:2]` and `adBus[27:24]` is ignored, so accesses alias into DWORDs 0 to 63.
- R6: When `mode2`=1, the index is {`adBus[27:24]`, `adBus[7:2]`}.
- R7: In the data phase, `cbeN` holds active-low byte enables. Lane i is bits 8i+7:8i. A write changes only enabled lanes. A read returns the stored byte in enabled lanes and zero in the others. `rdData` is zero when no read is in progress.
- R8: A read of index 64 (offset 100h) or any index at or above `NUM_REGS` returns zero.
- R9: A write to an index at or above `NUM_REGS` is claimed but changes no register.
- R10: A claimed write whose data phase has no byte enable asserted changes no register.
- R11: After reset `devsel` is 0. It stays 1 until a cycle with `dataValid`=1 and drops in the next cycle. An address phase seen while `devsel` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mode2 | input | 1 | 1 selects the PCI-X Mode 2 10-bit index |
| idsel | input | 1 | Device select for configuration cycles |
| addrValid | input | 1 | Marks the address phase |
| dataValid | input | 1 | Marks the data phase |
| adBus | input | 32 | Address/data bus value in the address phase |
| cbeN | input | 4 | Command in the address phase, active-low byte enables in the data phase |
| wrData | input | 32 | Write data for the data phase |
| devsel | output | 1 | Access claimed, held until the data phase completes |
| rdData | output | 32 | Masked read data during a claimed read |

## Verification
The embedded assertions watch every cycle for a claim that breaks the rules on alignment, command or function, for a write strobe that reaches past the implemented array, for a read that returns non-zero data outside it or in a disabled lane, and for `devsel` that stays high after a data phase. Some behaviour only the bench scenarios can show. These are the real index arithmetic in each mode (aliasing of the upper field versus joining it), lane merging across successive writes, the effect of writing the multi-function flag on later function 1 cycles, and the fact that discarded writes leave the other DWORDs untouched.

// File: rtl/cfg_dec_pkg.sv
package cfg_dec_pkg;
  localparam int IDX_W = 10;
  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;

  typedef struct packed {
    logic             wrEn;
    logic             rdEn;
    logic [3:0]       byteEn;
    logic [IDX_W-1:0] index;
  } cfg_strb_t;
endpackage

// File: rtl/cfg_dec_ctrl.sv
module cfg_dec_ctrl
  import cfg_dec_pkg::*;
#(
  parameter int NUM_REGS = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        mode2,
  input  logic        idsel,
  input  logic        addrValid,
  input  logic        dataValid,
  input  logic [31:0] adBus,
  input  logic [3:0]  cbeN,
  input  logic        multiFunc,
  output cfg_strb_t   strb,
  output logic        devsel
);
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_REGS);

  logic             busy;
  logic             wrQ;
  logic [IDX_W-1:0] idxQ;
  logic [2:0]       fnNum;
  logic             isCfgCmd;
  logic             fnOk;
  logic             claim;
  logic [IDX_W-1:0] idxNext;

  assign fnNum    = adBus[10:8];
  assign isCfgCmd = (cbeN == CMD_CFG_RD) || (cbeN == CMD_CFG_WR);
  assign fnOk     = (fnNum == 3'd0) || ((fnNum == 3'd1) && multiFunc);
  assign claim    = addrValid && !busy && idsel && isCfgCmd &&
                    (adBus[1:0] == 2'b00) && fnOk;
  assign idxNext  = mode2 ? {adBus[27:24], adBus[7:2]} : {4'b0000, adBus[7:2]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      wrQ  <= 1'b0;
      idxQ <= '0;
    end else if (claim) begin
      busy <= 1'b1;
      wrQ  <= cbeN[0];
      idxQ <= idxNext;
    end else if (busy && dataValid) begin
      busy <= 1'b0;
    end
  end

  always_comb begin
    strb.wrEn   = busy && dataValid && wrQ && ({1'b0, idxQ} < LIMIT);
    strb.rdEn   = busy && !wrQ;
    strb.byteEn = ~cbeN;
    strb.index  = idxQ;
  end

  assign devsel = busy;

  assert_misaligned_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !busy && (adBus[1:0] != 2'b00)) |=> !devsel);
  assert_cmd_filter_R3: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !busy && (cbeN != CMD_CFG_RD) && (cbeN != CMD_CFG_WR)) |=> !devsel);
  assert_func_filter_R4: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !busy && ((fnNum > 3'd1) || ((fnNum == 3'd1) && !multiFunc))) |=> !devsel);
  assert_devsel_release_R11: assert property (@(posedge clk) disable iff (!rstN)
    (devsel && dataValid) |=> !devsel);
  assert_no_select_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!devsel && !idsel) |=> !devsel);
endmodule

// File: rtl/cfg_dec_regs.sv
module cfg_dec_regs
  import cfg_dec_pkg::*;
#(
  parameter int NUM_REGS = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  cfg_strb_t   strb,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        multiFunc
);
  localparam int AW = $clog2(NUM_REGS);
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_REGS);
  localparam int HDR_DW   = 3;
  localparam int HDR_LANE = 2;
  localparam int HDR_BIT  = 7;

  logic          inRange;
  logic [AW-1:0] addr;

  assign inRange = {1'b0, strb.index} < LIMIT;
  assign addr    = strb.index[AW-1:0];

  for (genvar ln = 0; ln < 4; ln++) begin : gLane
    logic [7:0] mem [NUM_REGS];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < NUM_REGS; i++) mem[i] <= 8'h00;
      end else if (strb.wrEn && strb.byteEn[ln]) begin
        mem[addr] <= wrData[ln*8 +: 8];
      end
    end

    assign rdData[ln*8 +: 8] = (strb.rdEn && inRange && strb.byteEn[ln]) ? mem[addr] : 8'h00;

    if (ln == HDR_LANE) begin : gHdr
      assign multiFunc = mem[HDR_DW][HDR_BIT];
    end
  end

  assert_write_in_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |-> inRange);
  assert_high_space_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && !inRange) |-> (rdData == 32'h0));
  assert_lane_mask_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & ~{{8{strb.byteEn[3]}}, {8{strb.byteEn[2]}},
                {8{strb.byteEn[1]}}, {8{strb.byteEn[0]}}}) == 32'h0);
  assert_idle_read_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdEn |-> (rdData == 32'h0));
endmodule

// File: rtl/cfg_cycle_decoder.sv
module cfg_cycle_decoder
  import cfg_dec_pkg::*;
#(
  parameter int NUM_REGS = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        mode2,
  input  logic        idsel,
  input  logic        addrValid,
  input  logic        dataValid,
  input  logic [31:0] adBus,
  input  logic [3:0]  cbeN,
  input  logic [31:0] wrData,
  output logic        devsel,
  output logic [31:0] rdData
);
  cfg_strb_t strb;
  logic      multiFunc;

  cfg_dec_ctrl #(.NUM_REGS(NUM_REGS)) uCtrl (
    .clk(clk), .rstN(rstN), .mode2(mode2), .idsel(idsel),
    .addrValid(addrValid), .dataValid(dataValid), .adBus(adBus),
    .cbeN(cbeN), .multiFunc(multiFunc), .strb(strb), .devsel(devsel)
  );

  cfg_dec_regs #(.NUM_REGS(NUM_REGS)) uRegs (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .rdData(rdData), .multiFunc(multiFunc)
  );
endmodule

// File: tb/tb_cfg_cycle_decoder.sv
module tb_cfg_cycle_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mode2 = 1'b0;
  logic        idsel = 1'b0;
  logic        addrValid = 1'b0;
  logic        dataValid = 1'b0;
  logic [31:0] adBus = '0;
  logic [3:0]  cbeN = 4'hF;
  logic [31:0] wrData = '0;
  logic        devsel;
  logic [31:0] rdData;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  cfg_cycle_decoder dut (
    .clk(clk), .rstN(rstN), .mode2(mode2), .idsel(idsel),
    .addrValid(addrValid), .dataValid(dataValid), .adBus(adBus),
    .cbeN(cbeN), .wrData(wrData), .devsel(devsel), .rdData(rdData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference model, compared on every clock
  int unsigned mReg [64];
  bit          mBusy;
  bit          mWr;
  int          mIdx;

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mReg[i]) mReg[i] = 0;
      mBusy = 0; mWr = 0; mIdx = 0;
    end else begin
      int  fn;
      bit  mf;
      fn = int'(adBus[10:8]);
      mf = mReg[3][23];
      if (!mBusy && addrValid && idsel && (cbeN == 4'hA || cbeN == 4'hB) &&
          adBus[1:0] == 2'b00 && (fn == 0 || (fn == 1 && mf))) begin
        mBusy = 1;
        mWr   = (cbeN == 4'hB);
        mIdx  = mode2 ? int'(adBus[27:24]) * 64 + int'(adBus[7:2]) : int'(adBus[7:2]);
      end else if (mBusy && dataValid) begin
        if (mWr && mIdx < 64)
          for (int l = 0; l < 4; l++)
            if (!cbeN[l]) mReg[mIdx][l*8 +: 8] = wrData[l*8 +: 8];
        mBusy = 0;
      end
    end
    #2;
    if (rstN) begin
      logic [31:0] expRd;
      expRd = 0;
      if (mBusy && !mWr && mIdx < 64)
        for (int l = 0; l < 4; l++)
          if (!cbeN[l]) expRd[l*8 +: 8] = mReg[mIdx][l*8 +: 8];
      check("R1 devsel per-cycle", {31'b0, devsel}, {31'b0, mBusy});
      check("R7 rdData per-cycle", rdData, expRd);
    end
  end

  function automatic logic [31:0] mkAd(input int fn, input int upper, input int regN, input int low2);
    return {4'b0, 4'(upper), 13'b0, 3'(fn), 6'(regN), 2'(low2)};
  endfunction

  task automatic txn(input logic [3:0] cmd, input logic sel, input logic m2,
                     input logic [31:0] ad, input logic [3:0] be, input logic [31:0] wd,
                     output logic sawDev, output logic [31:0] rd);
    @(negedge clk);
    mode2 = m2; idsel = sel; addrValid = 1'b1; adBus = ad; cbeN = cmd;
    @(negedge clk);
    addrValid = 1'b0; idsel = 1'b0;
    sawDev = devsel;
    dataValid = 1'b1; cbeN = ~be; wrData = wd; adBus = wd;
    #1 rd = rdData;
    @(negedge clk);
    dataValid = 1'b0; cbeN = 4'hF;
    #1 check("R11 devsel released", {31'b0, devsel}, 32'h0);
  endtask

  task automatic wr(input logic m2, input int fn, input int up, input int r, input logic [3:0] be,
                    input logic [31:0] d, output logic sawDev);
    logic [31:0] rd;
    txn(4'hB, 1'b1, m2, mkAd(fn, up, r, 0), be, d, sawDev, rd);
  endtask

  task automatic rdc(input logic m2, input int fn, input int up, input int r, input logic [3:0] be,
                     output logic [31:0] rd);
    logic s;
    txn(4'hA, 1'b1, m2, mkAd(fn, up, r, 0), be, 32'h0, s, rd);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic s;
    logic [31:0] r;
    #1 check("R11 reset devsel", {31'b0, devsel}, 32'h0);
    check("R7 reset rdData", rdData, 32'h0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 full write then read
    wr(0, 0, 0, 5, 4'hF, 32'hA5A5_1234, s);
    check("R1 claim devsel", {31'b0, s}, 32'h1);
    rdc(0, 0, 0, 5, 4'hF, r); check("R1 readback", r, 32'hA5A5_1234);
    // R7 lanes
    wr(0, 0, 0, 5, 4'b0010, 32'h0000_FF00, s);
    rdc(0, 0, 0, 5, 4'hF, r); check("R7 partial write", r, 32'hA5A5_FF34);
    rdc(0, 0, 0, 5, 4'b0001, r); check("R7 masked read", r, 32'h0000_0034);
    // R2 type 1
    txn(4'hB, 1'b1, 0, mkAd(0, 0, 5, 1), 4'hF, 32'h1111_1111, s, r);
    check("R2 no devsel", {31'b0, s}, 32'h0);
    rdc(0, 0, 0, 5, 4'hF, r); check("R2 unchanged", r, 32'hA5A5_FF34);
    // R3 wrong command
    txn(4'h7, 1'b1, 0, mkAd(0, 0, 5, 0), 4'hF, 32'h2222_2222, s, r);
    check("R3 no devsel", {31'b0, s}, 32'h0);
    rdc(0, 0, 0, 5, 4'hF, r); check("R3 unchanged", r, 32'hA5A5_FF34);
    // R1 idsel low
    txn(4'hB, 1'b0, 0, mkAd(0, 0, 5, 0), 4'hF, 32'h3333_3333, s, r);
    check("R1 idsel low no devsel", {31'b0, s}, 32'h0);
    // R4 functions
    wr(0, 1, 0, 6, 4'hF, 32'hDEAD_0001, s);
    check("R4 fn1 rejected when flag clear", {31'b0, s}, 32'h0);
    wr(0, 0, 0, 3, 4'b0100, 32'h0080_0000, s);
    wr(0, 1, 0, 6, 4'hF, 32'hBEEF_0006, s);
    check("R4 fn1 claimed when flag set", {31'b0, s}, 32'h1);
    rdc(0, 1, 0, 6, 4'hF, r); check("R4 fn1 readback", r, 32'hBEEF_0006);
    wr(0, 2, 0, 6, 4'hF, 32'h0, s);
    check("R4 fn2 rejected", {31'b0, s}, 32'h0);
    // R5 aliasing
    wr(0, 0, 5, 7, 4'hF, 32'h7777_0007, s);
    rdc(0, 0, 0, 7, 4'hF, r); check("R5 upper ignored", r, 32'h7777_0007);
    // R6 / R8 / R9 mode 2
    wr(1, 0, 0, 9, 4'hF, 32'h9999_0009, s);
    rdc(0, 0, 0, 9, 4'hF, r); check("R6 mode2 low index", r, 32'h9999_0009);
    rdc(1, 0, 1, 0, 4'hF, r); check("R8 null header at 100h", r, 32'h0);
    wr(1, 0, 1, 0, 4'hF, 32'hFFFF_FFFF, s);
    check("R9 high write claimed", {31'b0, s}, 32'h1);
    rdc(1, 0, 1, 0, 4'hF, r); check("R9 discarded at 100h", r, 32'h0);
    rdc(0, 0, 0, 0, 4'hF, r); check("R9 dword0 untouched", r, 32'h0);
    rdc(1, 0, 15, 63, 4'hF, r); check("R8 top index zero", r, 32'h0);
    rdc(1, 0, 2, 9, 4'hF, r); check("R6 upper joined", r, 32'h0);
    rdc(0, 0, 2, 9, 4'hF, r); check("R5 alias in conventional", r, 32'h9999_0009);
    // R10 empty byte enables
    wr(0, 0, 0, 5, 4'h0, 32'h0BAD_0BAD, s);
    check("R10 claimed", {31'b0, s}, 32'h1);
    rdc(0, 0, 0, 5, 4'hF, r); check("R10 unchanged", r, 32'hA5A5_FF34);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule